// File: doc/BRIEF.md
# Modem Status Register Logic

This block watches four active-low modem handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) and presents them to a host as one 8-bit status byte. Each pin first passes through a multi-flop synchroniser. The upper nibble of the byte shows the present level of each line, inverted so that 1 means asserted. The lower nibble holds sticky change flags, and a host read clears them.

A loopback switch replaces the four pins with bits of the modem control register, so software can exercise the status path without external wiring. When interrupts are enabled, any set change flag raises a modem-status interrupt. A separate transmit-permit output implements automatic clear-to-send flow control. It only changes while no character is being sent, so a character that has started always finishes.

Top module: `modem_status_unit`

## Requirements
- R1: With `loop_en` low, `status[4]`, `status[5]`, `status[6]` and `status[7]` are the inverted synchronised levels of `cts_n_pin`, `dsr_n_pin`, `ri_n_pin` and `dcd_n_pin`, in that order.
- R2: With `loop_en` high, the pins are ignored and `status[4]` = `mctl[1]`, `status[5]` = `mctl[0]`, `status[6]` = `mctl[2]` and `status[7]` = `mctl[3]`.
- R3: `status[0]`, `status[1]` and `status[3]` are sticky flags. Each is set on the clock edge after any change of the level shown in `status[4]`, `status[5]` or `status[7]` respectively.
- R4: `status[2]` is set only when the ring level in `status[6]` falls from 1 to 0, which is the ring input returning high. A rising ring level leaves it unchanged.
- R5: A cycle with `status_rd` high clears all four change flags at the next edge. A change detected at that same edge keeps its flag set.
- R6: `msi_irq` is 1 exactly when `msi_en` is 1 and at least one of `status[3:0]` is 1.
- R7: With `auto_cts_en` low, `tx_permit` becomes 1 at the first edge where `tx_busy` is low. With it high, `tx_permit` takes the value of `status[4]` at each edge where `tx_busy` is low. While `tx_busy` is high, `tx_permit` holds its value.
- R8: A pin change first shows in the upper nibble after two rising clock edges, and in its change flag after three.
- R9: After reset, with all pins high, `status` is 0x00, `msi_irq` is 0 and `tx_permit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_pin | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_pin | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_pin | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n_pin | input | 1 | Carrier detect pin, active low, asynchronous |
| loop_en | input | 1 | Loopback select |
| mctl | input | 4 | Modem control bits: [0] DTR, [1] RTS, [2] aux 1, [3] aux 2 |
| status_rd | input | 1 | Host read strobe for the status byte |
| msi_en | input | 1 | Modem-status interrupt enable |
| auto_cts_en | input | 1 | Automatic clear-to-send flow control enable |
| tx_busy | input | 1 | A character is being transmitted |
| status | output | 8 | Status byte: [7:4] levels, [3:0] change flags |
| msi_irq | output | 1 | Modem-status interrupt |
| tx_permit | output | 1 | Transmitter may start a new character |

## Verification
The first patterns are single isolated pin toggles. They measure the synchroniser latency, and they separate ring edges in each direction, which tells the trailing-edge rule apart from an any-edge detector. Reads are then issued in the same cycle as a detected change and in a quiet cycle, which separates the priority of a new change from a plain clear. Loopback runs with the pins toggling, so a swapped bit mapping or a pin leaking through shows up. Long random runs of pin, control, busy and read activity are compared against a behavioural model on every clock. They catch flow-control updates made mid-character and interrupt gating errors.

// File: rtl/msr_pkg.sv
`timescale 1ns/1ps
package msr_pkg;
   localparam int unsigned NUM_LINES = 4;
   localparam int unsigned IDX_CTS = 0;
   localparam int unsigned IDX_DSR = 1;
   localparam int unsigned IDX_RI  = 2;
   localparam int unsigned IDX_CD  = 3;
   // control-register bit positions feeding loopback
   localparam int unsigned CTL_DTR = 0;
   localparam int unsigned CTL_RTS = 1;
   localparam int unsigned CTL_AUX1 = 2;
   localparam int unsigned CTL_AUX2 = 3;

   typedef logic [NUM_LINES-1:0] line_vec_t;
   typedef enum logic {EDGE_ANY = 1'b0, EDGE_TRAIL = 1'b1} edge_mode_e;
endpackage

// File: rtl/msr_sync.sv
`timescale 1ns/1ps
module msr_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad
         $error("msr_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d_async;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q_sync = chain[LAST];
endmodule

// File: rtl/msr_change_detect.sv
`timescale 1ns/1ps
module msr_change_detect
   import msr_pkg::*;
#(
   parameter edge_mode_e MODE = EDGE_ANY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic clr,
   output logic lvl_prev,
   output logic flag
);
   logic hit;

   generate
      if (MODE == EDGE_TRAIL) begin : g_trail
         // asserted level dropping back to idle
         assign hit = lvl_prev & ~lvl;
      end else begin : g_any
         assign hit = lvl_prev ^ lvl;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev <= 1'b0;
         flag     <= 1'b0;
      end else begin
         lvl_prev <= lvl;
         flag     <= (flag & ~clr) | hit;
      end
   end
endmodule

// File: rtl/msr_flow_gate.sv
`timescale 1ns/1ps
module msr_flow_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_en,
   input  logic cts_lvl,
   input  logic tx_busy,
   output logic permit
);
   logic permit_d;

   always_comb begin
      permit_d = permit;
      if (!tx_busy) permit_d = ~auto_en | cts_lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) permit <= 1'b1;
      else        permit <= permit_d;
   end
endmodule

// File: rtl/modem_status_unit.sv
`timescale 1ns/1ps
module modem_status_unit
   import msr_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cts_n_pin,
   input  logic       dsr_n_pin,
   input  logic       ri_n_pin,
   input  logic       dcd_n_pin,
   input  logic       loop_en,
   input  logic [3:0] mctl,
   input  logic       status_rd,
   input  logic       msi_en,
   input  logic       auto_cts_en,
   input  logic       tx_busy,
   output logic [7:0] status,
   output logic       msi_irq,
   output logic       tx_permit
);
   generate
      if (NUM_LINES != 4) begin : g_bad_lines
         $error("status byte layout assumes four lines");
      end
   endgenerate

   line_vec_t pins_n, pins_n_sync, pin_lvl, loop_lvl, eff_lvl, prev_lvl, flags;

   always_comb begin
      pins_n          = '1;
      pins_n[IDX_CTS] = cts_n_pin;
      pins_n[IDX_DSR] = dsr_n_pin;
      pins_n[IDX_RI]  = ri_n_pin;
      pins_n[IDX_CD]  = dcd_n_pin;
   end

   msr_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(pins_n),
      .q_sync (pins_n_sync)
   );

   assign pin_lvl = ~pins_n_sync;

   always_comb begin
      loop_lvl          = '0;
      loop_lvl[IDX_CTS] = mctl[CTL_RTS];
      loop_lvl[IDX_DSR] = mctl[CTL_DTR];
      loop_lvl[IDX_RI]  = mctl[CTL_AUX1];
      loop_lvl[IDX_CD]  = mctl[CTL_AUX2];
   end

   assign eff_lvl = loop_en ? loop_lvl : pin_lvl;

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         localparam edge_mode_e LINE_MODE = (i == IDX_RI) ? EDGE_TRAIL : EDGE_ANY;
         msr_change_detect #(.MODE(LINE_MODE)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (eff_lvl[i]),
            .clr     (status_rd),
            .lvl_prev(prev_lvl[i]),
            .flag    (flags[i])
         );
      end
   endgenerate

   msr_flow_gate u_flow (
      .clk    (clk),
      .rst_n  (rst_n),
      .auto_en(auto_cts_en),
      .cts_lvl(eff_lvl[IDX_CTS]),
      .tx_busy(tx_busy),
      .permit (tx_permit)
   );

   assign status  = {eff_lvl, flags};
   assign msi_irq = msi_en & (|flags);
endmodule

// File: rtl/msr_checker.sv
`timescale 1ns/1ps
module msr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       loop_en,
   input logic [3:0] mctl,
   input logic       status_rd,
   input logic       msi_en,
   input logic       auto_cts_en,
   input logic       tx_busy,
   input logic [7:0] status,
   input logic       msi_irq,
   input logic       tx_permit,
   input logic [3:0] lvl,
   input logic [3:0] lvl_prev
);
   // R2
   loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> status[7:4] == {mctl[3], mctl[2], mctl[0], mctl[1]});

   // R5
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && lvl == lvl_prev) |=> status[3:0] == 4'h0);

   // R3
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_rd |=> (status[3:0] & $past(status[3:0])) == $past(status[3:0]));

   // R4
   ri_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[2] && !(lvl_prev[2] && !lvl[2])) |=> !status[2]);

   // R6
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !msi_en |-> !msi_irq);

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |=> $stable(tx_permit));

   // R7
   auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_cts_en && !tx_busy) |=> tx_permit);
endmodule

bind modem_status_unit msr_checker u_msr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .loop_en    (loop_en),
   .mctl       (mctl),
   .status_rd  (status_rd),
   .msi_en     (msi_en),
   .auto_cts_en(auto_cts_en),
   .tx_busy    (tx_busy),
   .status     (status),
   .msi_irq    (msi_irq),
   .tx_permit  (tx_permit),
   .lvl        (eff_lvl),
   .lvl_prev   (prev_lvl)
);

// File: tb/modem_status_unit_tb.sv
`timescale 1ns/1ps
module modem_status_unit_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
   logic loop_en = 1'b0;
   logic [3:0] mctl = 4'h0;
   logic status_rd = 1'b0, msi_en = 1'b0, auto_cts_en = 1'b0, tx_busy = 1'b0;
   logic [7:0] status;
   logic msi_irq, tx_permit;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   modem_status_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .cts_n_pin(cts_n), .dsr_n_pin(dsr_n), .ri_n_pin(ri_n), .dcd_n_pin(dcd_n),
      .loop_en(loop_en), .mctl(mctl), .status_rd(status_rd), .msi_en(msi_en),
      .auto_cts_en(auto_cts_en), .tx_busy(tx_busy),
      .status(status), .msi_irq(msi_irq), .tx_permit(tx_permit)
   );

   // behavioural reference: two-cycle pin delay, sticky flags, boundary permit
   bit [3:0] pin_hist[$];
   bit [3:0] m_prev, m_flags;
   bit m_permit;

   function automatic bit [3:0] pins_now();
      return {dcd_n, ri_n, dsr_n, cts_n};
   endfunction

   function automatic bit [3:0] m_level();
      if (loop_en) return {mctl[3], mctl[2], mctl[0], mctl[1]};
      return ~pin_hist[0];
   endfunction

   task automatic reset_model();
      pin_hist = '{4'hF, 4'hF};
      m_prev = 4'h0;
      m_flags = 4'h0;
      m_permit = 1'b1;
   endtask

   initial reset_model();

   always @(posedge clk) begin
      if (!rst_n) reset_model();
      else begin
         bit [3:0] lv, hit;
         lv = m_level();
         for (int i = 0; i < 4; i++)
            hit[i] = (i == 2) ? (m_prev[i] && !lv[i]) : (m_prev[i] != lv[i]);
         m_flags = (status_rd ? 4'h0 : m_flags) | hit;
         m_prev = lv;
         if (!tx_busy) m_permit = !auto_cts_en || lv[0];
         void'(pin_hist.pop_front());
         pin_hist.push_back(pins_now());
      end
   end

   task automatic check(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #5;
      if (rst_n && !finished) begin
         bit [3:0] lv;
         lv = m_level();
         check(loop_en ? "R2 levels" : "R1 levels", status[7:4], lv);
         check("R3 flags cts/dsr/cd", {status[3], status[1:0]}, {m_flags[3], m_flags[1:0]});
         check("R4 ring flag", status[2], m_flags[2]);
         check("R6 irq", msi_irq, msi_en && (m_flags != 0));
         check("R7 permit", tx_permit, m_permit);
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_once();
      @(negedge clk) status_rd = 1'b1;
      @(negedge clk) status_rd = 1'b0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      @(posedge clk); #5;
      // R9 reset state
      check("R9 status", status, 8'h00);
      check("R9 irq", msi_irq, 0);
      check("R9 permit", tx_permit, 1);

      // R8 latency: cts low before edge k, level after k+1, flag after k+2
      @(negedge clk) cts_n = 1'b0;
      @(posedge clk); #5 check("R8 not yet", status[4], 0);
      @(posedge clk); #5 check("R8 level", status[4], 1);
      check("R8 flag early", status[0], 0);
      @(posedge clk); #5 check("R8 flag", status[0], 1);
      read_once();
      step(2);

      // R4 leading ring edge ignored, trailing edge flagged
      ri_n = 1'b0; step(5);
      check("R4 leading", status[2], 0);
      ri_n = 1'b1; step(5);
      check("R4 trailing", status[2], 1);

      // R5 read in quiet cycle clears, read coinciding with change keeps flag
      msi_en = 1'b1; read_once(); step(1);
      check("R5 clear", status[3:0], 4'h0);
      check("R6 irq low", msi_irq, 0);
      dsr_n = 1'b0; step(2);             // level changes at next edge
      status_rd = 1'b1; step(1); status_rd = 1'b0;
      check("R5 priority", status[1], 1);
      check("R6 irq high", msi_irq, 1);

      // R2 loopback with pins moving
      loop_en = 1'b1; mctl = 4'b0010; cts_n = 1'b1; step(3);
      check("R2 rts->bit4", status[7:4], 4'b0001);
      mctl = 4'b1101; step(1);
      check("R2 map", status[7:4], 4'b1110);
      loop_en = 1'b0; mctl = 4'h0;

      // R7 boundary hold
      auto_cts_en = 1'b1; tx_busy = 1'b1; cts_n = 1'b1; step(4);
      check("R7 hold busy", tx_permit, 1);
      tx_busy = 1'b0; step(1);
      check("R7 stop at boundary", tx_permit, 0);

      // random traffic compared every clock
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         if ($urandom_range(0, 5) == 0) cts_n = ~cts_n;
         if ($urandom_range(0, 7) == 0) dsr_n = ~dsr_n;
         if ($urandom_range(0, 6) == 0) ri_n = ~ri_n;
         if ($urandom_range(0, 8) == 0) dcd_n = ~dcd_n;
         if ($urandom_range(0, 60) == 0) loop_en = ~loop_en;
         if ($urandom_range(0, 9) == 0) mctl = 4'($urandom);
         status_rd = ($urandom_range(0, 4) == 0);
         if ($urandom_range(0, 30) == 0) msi_en = ~msi_en;
         if ($urandom_range(0, 40) == 0) auto_cts_en = ~auto_cts_en;
         if ($urandom_range(0, 3) == 0) tx_busy = ~tx_busy;
      end
      step(2);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         finished = 1'b1;
         miscompares++;
         $display("FAIL watchdog: actual running expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule